// File: doc/BRIEF.md
# Memory Data Poisoning Unit

This block sits in the datapath of a DRAM controller, between the ECC logic and the consumers of the data. It marks data known to be corrupt so that a later consumer detects it. When the ECC checker flags a read beat as an uncorrectable double-bit error, the block inverts the byte-parity bits that go out with the returned data. When a write beat arrives with a parity error, it inverts the ECC check byte before the beat goes to DRAM. The data bits themselves are never altered, and an errored beat is never held back or replayed. Every beat leaves exactly once, four clock edges after it entered.

The amount of data marked depends on the direction and on which requester issued the command:

| Direction | Requester | Granule |
|---|---|---|
| Read | Host bridge | 32 bytes |
| Read | I/O memory target | 8 bytes |
| Write | Host bridge | 16 bytes |
| Write | I/O memory target | 8 bytes |

A granule is aligned on the low bits of the beat address. A granule of 16 or 32 bytes spans two or four 64-bit beats. The block therefore holds beats in a four-stage line. An error seen on any beat of a granule then reaches the beats that came before it. ECC must be enabled, together with a per-direction poison enable, for marking to take place. Each granule that is marked raises a one-cycle pulse for external logging.

Top module: `mem_poison_unit`

## Requirements
- R1: A beat presented with `in_valid` high appears on the outputs exactly four rising edges later, with `out_data`, `out_wr` and `out_io` unchanged. `out_chk` is either the input check byte or its bitwise inverse.
- R2: On a read from the host bridge (`in_wr`=0, `in_io`=0), a set `in_err` on any beat inverts `out_chk` of every beat of the same 32-byte granule, which is `in_beat_addr[AW-1:2]`. The granule covers up to four beats.
- R3: On a read from the I/O memory target (`in_wr`=0, `in_io`=1), only the beat whose `in_err` is set has its `out_chk` inverted, since the granule is 8 bytes.
- R4: On a write from the host bridge (`in_wr`=1, `in_io`=0), a set `in_err` inverts `out_chk` of both beats of the 16-byte granule, which is `in_beat_addr[AW-1:1]`.
- R5: On a write from the I/O memory target (`in_wr`=1, `in_io`=1), only the errored beat has its `out_chk` inverted.
- R6: Beats of a neighbouring granule pass with `out_chk` unchanged, even when they follow an errored granule on the very next cycle.
- R7: While `cfg_ecc_en` is low when a beat enters, that beat leaves with its check byte unchanged, whatever the poison enables are.
- R8: While `cfg_rd_poison_en` is low, read beats pass unchanged and write poisoning still works.
- R9: While `cfg_wr_poison_en` is low, write beats pass unchanged and read poisoning still works.
- R10: `poison_evt` is high for exactly one cycle per marked granule, in the cycle its first marked beat is on the outputs, and never otherwise.
- R11: Errored beats are neither retried nor duplicated. The number of beats leaving equals the number entering.
- R12: During reset `out_valid` and `poison_evt` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ecc_en | input | 1 | ECC enabled |
| cfg_rd_poison_en | input | 1 | Allow marking of read data |
| cfg_wr_poison_en | input | 1 | Allow marking of write data |
| in_valid | input | 1 | Beat present |
| in_wr | input | 1 | 1 = write to DRAM, 0 = read from DRAM |
| in_io | input | 1 | 1 = I/O memory target, 0 = host bridge |
| in_beat_addr | input | AW (29) | Beat address in 8-byte units |
| in_err | input | 1 | Double-bit error (read) or parity error (write) on this beat |
| in_data | input | DW (64) | Data beat |
| in_chk | input | CW (8) | Byte parity (read) or ECC check byte (write) |
| out_valid | output | 1 | Beat present |
| out_wr | output | 1 | Direction of the beat |
| out_io | output | 1 | Requester of the beat |
| out_data | output | DW (64) | Data beat, unchanged |
| out_chk | output | CW (8) | Check bits, inverted when marked |
| poison_evt | output | 1 | One-cycle pulse per marked granule |

## Verification
The assertions take the configuration enables as stable while any beat that entered under them is still in flight. They take the beats of a granule as arriving on back-to-back cycles. They also assume that a run of consecutive beats of one class never revisits the same granule beyond its size, because the block treats such a run as one granule. The stimulus meets all three conditions in the following ways:
- It changes the enables only after an idle gap longer than the line.
- It gives every burst a fresh 64-byte-aligned address region.
- It sends the beats of a burst without gaps, and places gaps only between bursts.

// File: rtl/mem_poison_unit.sv
module mem_poison_unit #(
  parameter int DW            = 64,
  parameter int CW            = 8,
  parameter int AW            = 29,
  parameter int RD_HOST_BYTES = 32,
  parameter int RD_IO_BYTES   = 8,
  parameter int WR_HOST_BYTES = 16,
  parameter int WR_IO_BYTES   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ecc_en,
  input  logic          cfg_rd_poison_en,
  input  logic          cfg_wr_poison_en,
  input  logic          in_valid,
  input  logic          in_wr,
  input  logic          in_io,
  input  logic [AW-1:0] in_beat_addr,
  input  logic          in_err,
  input  logic [DW-1:0] in_data,
  input  logic [CW-1:0] in_chk,
  output logic          out_valid,
  output logic          out_wr,
  output logic          out_io,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_chk,
  output logic          poison_evt
);

  localparam int BEAT_BYTES = DW / 8;
  localparam int BEAT_LG    = $clog2(BEAT_BYTES);
  localparam int SH_RD_HOST = $clog2(RD_HOST_BYTES) - BEAT_LG;
  localparam int SH_RD_IO   = $clog2(RD_IO_BYTES) - BEAT_LG;
  localparam int SH_WR_HOST = $clog2(WR_HOST_BYTES) - BEAT_LG;
  localparam int SH_WR_IO   = $clog2(WR_IO_BYTES) - BEAT_LG;
  localparam int MAX_RD     = (RD_HOST_BYTES > RD_IO_BYTES) ? RD_HOST_BYTES : RD_IO_BYTES;
  localparam int MAX_WR     = (WR_HOST_BYTES > WR_IO_BYTES) ? WR_HOST_BYTES : WR_IO_BYTES;
  localparam int MAX_BYTES  = (MAX_RD > MAX_WR) ? MAX_RD : MAX_WR;
  localparam int DEPTH      = MAX_BYTES / BEAT_BYTES;
  localparam int OS         = DEPTH - 1;

  function automatic logic same_gran(input logic wa, input logic ia, input logic [AW-1:0] a,
                                     input logic wb, input logic ib, input logic [AW-1:0] b);
    int sh;
    sh = wa ? (ia ? SH_WR_IO : SH_WR_HOST) : (ia ? SH_RD_IO : SH_RD_HOST);
    return (wa == wb) && (ia == ib) && ((a >> sh) == (b >> sh));
  endfunction

  logic [DEPTH-1:0] st_v, st_wr, st_io, st_err, st_pen;
  logic [AW-1:0]    st_addr [DEPTH];
  logic [DW-1:0]    st_data [DEPTH];
  logic [CW-1:0]    st_chk  [DEPTH];

  logic          hold_v, hold_wr, hold_io, hold_flag, hold_pois;
  logic [AW-1:0] hold_addr;

  logic [DEPTH-1:0] chain;
  logic             look_flag, cont, run_flag, out_pois;

  wire in_pen = cfg_ecc_en & (in_wr ? cfg_wr_poison_en : cfg_rd_poison_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_v <= '0; st_wr <= '0; st_io <= '0; st_err <= '0; st_pen <= '0;
    end else begin
      st_v   <= {st_v[DEPTH-2:0],   in_valid};
      st_wr  <= {st_wr[DEPTH-2:0],  in_wr};
      st_io  <= {st_io[DEPTH-2:0],  in_io};
      st_err <= {st_err[DEPTH-2:0], in_err & in_valid};
      st_pen <= {st_pen[DEPTH-2:0], in_pen};
    end
  end

  always_ff @(posedge clk) begin
    st_addr[0] <= in_beat_addr;
    st_data[0] <= in_data;
    st_chk[0]  <= in_chk;
  end

  generate
    for (genvar k = 1; k < DEPTH; k++) begin : g_line
      always_ff @(posedge clk) begin
        st_addr[k] <= st_addr[k-1];
        st_data[k] <= st_data[k-1];
        st_chk[k]  <= st_chk[k-1];
      end
    end
  endgenerate

  always_comb begin
    chain[OS] = st_v[OS];
    for (int k = OS - 1; k >= 0; k--)
      chain[k] = chain[k+1] & st_v[k] &
                 same_gran(st_wr[k], st_io[k], st_addr[k], st_wr[OS], st_io[OS], st_addr[OS]);
  end

  assign look_flag = |(chain & st_err);
  assign cont      = hold_v & st_v[OS] &
                     same_gran(hold_wr, hold_io, hold_addr, st_wr[OS], st_io[OS], st_addr[OS]);
  assign run_flag  = look_flag | (cont & hold_flag);
  assign out_pois  = st_v[OS] & st_pen[OS] & run_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0; hold_wr <= 1'b0; hold_io <= 1'b0;
      hold_flag <= 1'b0; hold_pois <= 1'b0; hold_addr <= '0;
    end else begin
      hold_v    <= st_v[OS];
      hold_wr   <= st_wr[OS];
      hold_io   <= st_io[OS];
      hold_addr <= st_addr[OS];
      hold_flag <= run_flag;
      hold_pois <= out_pois;
    end
  end

  assign out_valid  = st_v[OS];
  assign out_wr     = st_wr[OS];
  assign out_io     = st_io[OS];
  assign out_data   = st_data[OS];
  assign out_chk    = out_pois ? ~st_chk[OS] : st_chk[OS];
  assign poison_evt = out_pois & ~(cont & hold_pois);

endmodule

// File: rtl/mem_poison_unit_chk.sv
module mem_poison_unit_chk #(
  parameter int DW = 64,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_ecc_en,
  input logic          cfg_rd_poison_en,
  input logic          cfg_wr_poison_en,
  input logic          in_valid,
  input logic          in_err,
  input logic [DW-1:0] in_data,
  input logic [CW-1:0] in_chk,
  input logic          out_valid,
  input logic          out_wr,
  input logic          out_io,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] out_chk,
  input logic          poison_evt
);

  AST_DATA_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == $past(in_data, 4)); // R1

  AST_CHK_PASS_OR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chk == $past(in_chk, 4) || out_chk == ~$past(in_chk, 4))); // R1

  AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && $past(rst_n, 3) && $past(rst_n, 4))
      |-> out_valid == $past(in_valid, 4)); // R11

  AST_ECC_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(cfg_ecc_en, 4)) |-> out_chk == $past(in_chk, 4)); // R7

  AST_RD_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wr && !$past(cfg_rd_poison_en, 4)) |-> out_chk == $past(in_chk, 4)); // R8

  AST_WR_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wr && !$past(cfg_wr_poison_en, 4)) |-> out_chk == $past(in_chk, 4)); // R9

  AST_IO_RD_OWN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_io && !out_wr && $past(cfg_ecc_en, 4) && $past(cfg_rd_poison_en, 4))
      |-> ((out_chk == ~$past(in_chk, 4)) == $past(in_err, 4))); // R3

  AST_IO_WR_OWN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_io && out_wr && $past(cfg_ecc_en, 4) && $past(cfg_wr_poison_en, 4))
      |-> ((out_chk == ~$past(in_chk, 4)) == $past(in_err, 4))); // R5

  AST_EVT_ON_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    poison_evt |-> (out_valid && out_chk == ~$past(in_chk, 4))); // R10

endmodule

bind mem_poison_unit mem_poison_unit_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ecc_en(cfg_ecc_en),
  .cfg_rd_poison_en(cfg_rd_poison_en), .cfg_wr_poison_en(cfg_wr_poison_en),
  .in_valid(in_valid), .in_err(in_err), .in_data(in_data), .in_chk(in_chk),
  .out_valid(out_valid), .out_wr(out_wr), .out_io(out_io), .out_data(out_data),
  .out_chk(out_chk), .poison_evt(poison_evt)
);

// File: tb/mem_poison_unit_bench.sv
module mem_poison_unit_bench;
  localparam int DW = 64, CW = 8, AW = 29, N = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_ecc_en = 1'b1, cfg_rd_poison_en = 1'b1, cfg_wr_poison_en = 1'b1;
  logic in_valid = 1'b0, in_wr = 1'b0, in_io = 1'b0, in_err = 1'b0;
  logic [AW-1:0] in_beat_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic [CW-1:0] in_chk = '0;
  logic out_valid, out_wr, out_io, poison_evt;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_chk;

  mem_poison_unit u_mem_poison_unit (.*);

  always #5 clk = ~clk;

  int vectors = 0, misses = 0, cyc = 0, n_in = 0, n_out = 0;
  bit done = 0;
  logic          h_v [N], h_wr [N], h_io [N], h_err [N], h_ecc [N], h_rde [N], h_wre [N];
  logic [AW-1:0] h_a [N];
  logic [DW-1:0] h_d [N];
  logic [CW-1:0] h_c [N];

  always @(posedge clk) begin
    if (cyc < N) begin
      h_v[cyc] = rst_n & in_valid; h_wr[cyc] = in_wr; h_io[cyc] = in_io;
      h_err[cyc] = in_err; h_a[cyc] = in_beat_addr; h_d[cyc] = in_data; h_c[cyc] = in_chk;
      h_ecc[cyc] = cfg_ecc_en; h_rde[cyc] = cfg_rd_poison_en; h_wre[cyc] = cfg_wr_poison_en;
    end
    if (rst_n && in_valid) n_in++;
    cyc++;
  end

  function automatic int gran_beats(input logic wr, input logic io);
    if (io) return 1;
    return wr ? 2 : 4;
  endfunction

  function automatic bit same(input int a, input int b);
    int g;
    g = gran_beats(h_wr[a], h_io[a]);
    return h_v[a] && h_v[b] && h_wr[a] == h_wr[b] && h_io[a] == h_io[b] &&
           (h_a[a] / g) == (h_a[b] / g);
  endfunction

  function automatic bit enabled(input int i);
    return h_ecc[i] && (h_wr[i] ? h_wre[i] : h_rde[i]);
  endfunction

  function automatic bit marked(input int i, input int last);
    bit f;
    f = 0;
    if (!h_v[i] || !enabled(i)) return 0;
    for (int k = i; k >= 0 && same(k, i); k--) f |= h_err[k];
    for (int k = i + 1; k <= last && same(k, i); k++) f |= h_err[k];
    return f;
  endfunction

  function automatic string chk_tag(input int i, input bit m);
    if (!h_ecc[i]) return "R7";
    if (!h_wr[i] && !h_rde[i]) return "R8";
    if (h_wr[i] && !h_wre[i]) return "R9";
    if (!m) return "R6";
    if (!h_wr[i]) return h_io[i] ? "R3" : "R2";
    return h_io[i] ? "R5" : "R4";
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done && cyc >= 4 && cyc - 1 < N) begin
      int i;
      bit m, ev;
      logic [CW-1:0] ec;
      i = cyc - 4;
      vectors++;
      if (out_valid !== h_v[i]) begin
        misses++; $display("FAIL R1 out_valid act=%b exp=%b cyc=%0d", out_valid, h_v[i], cyc);
      end else if (h_v[i]) begin
        n_out++;
        m  = marked(i, cyc - 1);
        ev = m && !(i > 0 && same(i - 1, i) && marked(i - 1, cyc - 1));
        ec = m ? ~h_c[i] : h_c[i];
        if (out_data !== h_d[i] || out_wr !== h_wr[i] || out_io !== h_io[i]) begin
          misses++; $display("FAIL R1 data act=%h exp=%h cyc=%0d", out_data, h_d[i], cyc);
        end
        if (out_chk !== ec) begin
          misses++; $display("FAIL %s out_chk act=%h exp=%h cyc=%0d", chk_tag(i, m), out_chk, ec, cyc);
        end
        if (poison_evt !== ev) begin
          misses++; $display("FAIL R10 poison_evt act=%b exp=%b cyc=%0d", poison_evt, ev, cyc);
        end
      end else if (poison_evt !== 1'b0) begin
        misses++; $display("FAIL R10 poison_evt on idle act=%b exp=0 cyc=%0d", poison_evt, cyc);
      end
    end
  end

  int region = 0;

  task automatic beat(input logic wr, input logic io, input int addr, input logic err);
    in_valid = 1; in_wr = wr; in_io = io; in_beat_addr = AW'(addr); in_err = err;
    in_data = {$urandom(), $urandom()}; in_chk = CW'($urandom());
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    in_valid = 0; in_err = 0;
    repeat (k) @(negedge clk);
  endtask

  task automatic burst(input int kind, input int errpos);
    int base, nb;
    bit wr, io;
    base = region * 8; region++;
    case (kind)
      0: begin wr = 0; io = 0; nb = 4; end
      1: begin wr = 0; io = 1; nb = 1; base += $urandom_range(0, 7); end
      2: begin wr = 1; io = 0; nb = ($urandom_range(0, 1) == 1) ? 4 : 2; end
      default: begin wr = 1; io = 1; nb = 1; base += $urandom_range(0, 7); end
    endcase
    for (int b = 0; b < nb; b++)
      beat(wr, io, base + b, (errpos == b) || (errpos < 0 && $urandom_range(0, 5) == 0));
  endtask

  task automatic phase(input logic e, input logic r, input logic w, input int cnt);
    idle(6);
    cfg_ecc_en = e; cfg_rd_poison_en = r; cfg_wr_poison_en = w;
    burst(0, 3); burst(0, 0); burst(2, 1); burst(2, 0); burst(1, 0); burst(1, 9); burst(3, 0);
    for (int k = 0; k < cnt; k++) begin
      burst($urandom_range(0, 3), -1);
      idle($urandom_range(0, 2));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || poison_evt !== 1'b0) begin
      misses++; $display("FAIL R12 reset outputs act=%b%b exp=00", out_valid, poison_evt);
    end
    rst_n = 1;
    @(negedge clk);
    phase(1, 1, 1, 120);
    phase(0, 1, 1, 40);
    phase(1, 0, 1, 40);
    phase(1, 1, 0, 40);
    idle(8);
    done = 1;
    vectors++;
    if (n_out != n_in) begin
      misses++; $display("FAIL R11 beats out act=%0d exp=%0d", n_out, n_in);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #(1_000_000);
    misses++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule